// File: doc/BRIEF.md
# Asynchronous interrupt pulse capture

This block catches an interrupt pulse that can arrive at any moment, even one shorter than a clock period, and holds it in a sticky flag until a synchronous clear request removes it. The pulse drives the asynchronous set of a single capture flop. That flop feeds its own output back to its data input through a clear gate, so the flag holds its value on every clock edge until a clear is requested. A chain of synchronizer flops carries the flag into the clock domain. This chain also absorbs any metastability that appears when the set is released close to an edge.

The block also conditions the active-low system reset. The conditioned reset asserts as soon as the reset input goes low. It releases only after the inactive level has passed through a short flop chain. The conditioned reset clears the flag and the output synchronizer, and it is also available as an output for neighbouring logic.

Top module: `irq_capture`

## Requirements
- R1: While `rst_n` is low, `rst_n_sync` and `irq_out` are 0 at once, without waiting for a clock edge.
- R2: After `rst_n` rises, `rst_n_sync` stays 0 through the first rising clock edge and becomes 1 at the second rising edge.
- R3: A high pulse on `irq_pulse` of any phase relative to the clock sets the flag. The pulse may begin and end between two rising edges. `irq_out` is still 0 after the first rising edge that follows the pulse and is 1 after the second.
- R4: Once `irq_out` is 1 and `clr_req` stays 0, `irq_out` stays 1 on every later edge.
- R5: If `clr_req` is 1 at a rising edge E while `irq_pulse` is 0, the flag clears at E. `irq_out` is still 1 after E+1 and is 0 after E+2.
- R6: If `irq_pulse` is 1 at a rising edge where `clr_req` is also 1, the set wins. The flag and `irq_out` stay 1 after both inputs return to 0.
- R7: A pulse on `irq_pulse` while the conditioned reset is active is discarded. After the reset releases, `irq_out` stays 0.
- R8: A clear request when no flag is pending leaves `irq_out` at 0. A later pulse is captured as in R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset, may change at any time |
| irq_pulse | input | 1 | Interrupt pulse, active high, asynchronous to `clk` |
| clr_req | input | 1 | Synchronous request to clear the pending flag |
| irq_out | output | 1 | Synchronized pending-interrupt output |
| rst_n_sync | output | 1 | Conditioned active-low reset |

## Verification
The hardest case is a pulse that begins and ends entirely between two rising edges. No clock edge ever sees such a pulse high, so only the asynchronous set can record it. The bench places 1 ns pulses at each whole-nanosecond offset from 1 to 6 ns after an edge and counts the rising edges until `irq_out` rises. The second hard case is a set that overlaps a clear request. The bench holds `irq_pulse` and `clr_req` high across the same edge, and then checks that the flag survives the clear.

// File: rtl/irq_capture_pkg.sv
package irq_capture_pkg;
  parameter int unsigned RST_CHAIN_DEF = 2;
  parameter int unsigned OUT_CHAIN_DEF = 2;
  parameter int unsigned CHAIN_MIN     = 2;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] stg;

  generate
    if (STAGES < irq_capture_pkg::CHAIN_MIN) begin : g_bad
      initial $error("sync_chain: STAGES below minimum");
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg <= {STAGES{RST_VAL}};
    else         stg <= {stg[LAST-1:0], d};
  end

  assign q = stg[LAST];
endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
  input  logic clk,
  input  logic arst_n,
  input  logic set_in,
  input  logic clr_req,
  output logic flag
);
  logic next_d;

  // Feedback: hold while no clear is requested.
  assign next_d = flag & ~clr_req;

  // Reset has priority, then the asynchronous set, then the feedback.
  always_ff @(posedge clk or posedge set_in or negedge arst_n) begin
    if (!arst_n)     flag <= 1'b0;
    else if (set_in) flag <= 1'b1;
    else             flag <= next_d;
  end
endmodule

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int unsigned RST_STAGES = irq_capture_pkg::RST_CHAIN_DEF,
  parameter int unsigned OUT_STAGES = irq_capture_pkg::OUT_CHAIN_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_pulse,
  input  logic clr_req,
  output logic irq_out,
  output logic rst_n_sync
);
  logic irq_flag;

  // Reset conditioning: the inactive level ripples through the chain.
  sync_chain #(.STAGES(RST_STAGES), .RST_VAL(1'b0)) u_rst_cond (
    .clk    (clk),
    .arst_n (rst_n),
    .d      (1'b1),
    .q      (rst_n_sync)
  );

  irq_flag_cell u_flag (
    .clk     (clk),
    .arst_n  (rst_n_sync),
    .set_in  (irq_pulse),
    .clr_req (clr_req),
    .flag    (irq_flag)
  );

  sync_chain #(.STAGES(OUT_STAGES), .RST_VAL(1'b0)) u_out_sync (
    .clk    (clk),
    .arst_n (rst_n_sync),
    .d      (irq_flag),
    .q      (irq_out)
  );
endmodule

// File: rtl/irq_capture_chk.sv
module irq_capture_chk (
  input logic clk,
  input logic rst_n,
  input logic rst_n_sync,
  input logic irq_pulse,
  input logic clr_req,
  input logic flag,
  input logic irq_out
);
  // R2: the conditioned reset only releases after the raw reset was high at the previous edge
  a_r2_release_late: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n_sync) |-> $past(rst_n));

  // R4: a held flag with no clear request survives the edge
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (flag && !clr_req) |=> flag);

  // R6: a set seen at an edge beats a simultaneous clear
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (irq_pulse && clr_req) |=> flag);

  // R3: the output rises only two edges after the flag was seen set
  a_r3_rise_latency: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $rose(irq_out) |-> $past(flag, 2));

  // R5: the output falls only two edges after the flag was seen clear
  a_r5_fall_latency: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $fell(irq_out) |-> !$past(flag, 2));

  // R7: the output is low in the first cycle after reset release
  a_r7_quiet_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n_sync) |-> !irq_out);
endmodule

bind irq_capture irq_capture_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_n_sync (rst_n_sync),
  .irq_pulse  (irq_pulse),
  .clr_req    (clr_req),
  .flag       (irq_flag),
  .irq_out    (irq_out)
);

// File: tb/irq_capture_bench.sv
`timescale 1ns/1ps
module irq_capture_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic irq_pulse;
  logic clr_req;
  logic irq_out;
  logic rst_n_sync;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  irq_capture u_irq_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_pulse  (irq_pulse),
    .clr_req    (clr_req),
    .irq_out    (irq_out),
    .rst_n_sync (rst_n_sync)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic after_edge();
    @(posedge clk);
    #1;
  endtask

  // Short pulse placed between edges, offset ph ns after an edge.
  task automatic short_pulse(input int ph);
    @(posedge clk);
    #(ph);
    irq_pulse = 1'b1;
    #1;
    irq_pulse = 1'b0;
  endtask

  task automatic do_clear(input string req);
    @(negedge clk); clr_req = 1'b1;
    @(negedge clk); clr_req = 1'b0;
    after_edge();
    check(req, irq_out, 1'b1);
    after_edge();
    check(req, irq_out, 1'b0);
  endtask

  task automatic t_reset_release();
    rst_n = 1'b0;
    #1;
    check("R1", rst_n_sync, 1'b0);
    check("R1", irq_out, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    after_edge();
    check("R2", rst_n_sync, 1'b0);
    after_edge();
    check("R2", rst_n_sync, 1'b1);
    check("R2", irq_out, 1'b0);
  endtask

  task automatic t_short_capture();
    short_pulse(3);
    after_edge();
    check("R3", irq_out, 1'b0);
    after_edge();
    check("R3", irq_out, 1'b1);
  endtask

  task automatic t_sticky();
    for (int i = 0; i < 6; i++) begin
      after_edge();
      check("R4", irq_out, 1'b1);
    end
  endtask

  task automatic t_phase_sweep();
    for (int ph = 1; ph <= 6; ph++) begin
      int n;
      short_pulse(ph);
      n = 0;
      while (irq_out !== 1'b1 && n < 5) begin
        after_edge();
        n++;
      end
      checks++;
      if (n != 2) begin
        fails++;
        $display("FAIL R3: phase %0d took %0d edges expected 2", ph, n);
      end
      do_clear("R5");
    end
  endtask

  task automatic t_set_wins();
    @(negedge clk); clr_req = 1'b1; irq_pulse = 1'b1;
    @(negedge clk); clr_req = 1'b0; irq_pulse = 1'b0;
    repeat (4) after_edge();
    check("R6", irq_out, 1'b1);
    do_clear("R5");
  endtask

  task automatic t_reset_discard();
    @(posedge clk);
    #3; rst_n = 1'b0;
    #1;
    check("R1", rst_n_sync, 1'b0);
    check("R1", irq_out, 1'b0);
    #2; irq_pulse = 1'b1;
    #1; irq_pulse = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (2) after_edge();
    check("R2", rst_n_sync, 1'b1);
    repeat (4) after_edge();
    check("R7", irq_out, 1'b0);
  endtask

  task automatic t_idle_clear();
    @(negedge clk); clr_req = 1'b1;
    @(negedge clk); clr_req = 1'b0;
    repeat (3) after_edge();
    check("R8", irq_out, 1'b0);
    short_pulse(5);
    repeat (2) after_edge();
    check("R8", irq_out, 1'b1);
    do_clear("R8");
  endtask

  initial begin
    irq_pulse = 1'b0;
    clr_req   = 1'b0;
    t_reset_release();
    t_short_capture();
    t_sticky();
    do_clear("R5");
    t_phase_sweep();
    t_set_wins();
    t_short_capture();
    t_reset_discard();
    t_idle_clear();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule